// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. A one-cycle start request latches a channel number, a resolution mode and two phase lengths. The block then leaves its low-power state, waits a fixed wake-up interval, and holds the sample-enable line high for the programmed sampling time. After that it runs a binary search from the most significant bit downward. For each bit it presents a trial code to the external DAC and comparator, waits the programmed step time, and keeps or drops that bit according to the comparator answer.

When the last bit is resolved, the result and its channel appear together with a one-cycle done strobe. The block then falls back into power-down until the next request. In reduced-resolution mode the search stops after eight bits, which shortens the conversion. The analog comparator, the DAC and the input pads are outside the block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, pd_o is 1 and busy_o, done_o, sample_en_o, result_o and result_chan_o are all 0.
- R2: A start_i seen while idle raises busy_o and drops pd_o in the next cycle. sample_en_o rises exactly 4 cycles after that edge, so the wake-up interval is 4 cycles.
- R3: sample_en_o stays high for max(samp_len_i,1) consecutive cycles, using the value latched at start.
- R4: Each bit step lasts max(step_len_i,1) cycles, so done_o rises 4 + max(samp_len_i,1) + B*max(step_len_i,1) cycles after the start edge, with B = 10 in full mode and B = 8 in reduced mode.
- R5: The search starts at bit 9. During a step, trial_code_o equals the bits already kept OR the bit under test. cmp_i = 1 on the last cycle of the step means the input is at or above the trial code, and the bit is kept.
- R6: With mode8_i = 0, result_o equals the 10-bit binary-search outcome, which is the input code for an ideal comparator.
- R7: With mode8_i = 1, only bits 9 down to 2 are resolved. result_o holds them in place and bits 1:0 are 0.
- R8: done_o is high for exactly one cycle. result_o and result_chan_o (the latched chan_i) change only in that cycle and otherwise hold their values.
- R9: A start_i while busy_o is 1 is ignored: the running conversion keeps its channel, mode and timing.
- R10: In the done cycle busy_o is 0 and pd_o is 1. A start_i in that same cycle is accepted, so back-to-back conversions lose no cycle.
- R11: chan_i, mode8_i, samp_len_i and step_len_i are sampled only on the accepted start edge. Later changes do not affect the running conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request pulse |
| chan_i | input | CH_W | Channel number tagged to the result |
| mode8_i | input | 1 | 1 selects reduced 8-bit resolution |
| samp_len_i | input | CNT_W | Sampling phase length in cycles (0 acts as 1) |
| step_len_i | input | CNT_W | Cycles per resolved bit (0 acts as 1) |
| cmp_i | input | 1 | Comparator: 1 when input is at or above trial code |
| sample_en_o | output | 1 | Sample-and-hold enable |
| trial_code_o | output | RES | Code driven to the DAC |
| pd_o | output | 1 | Analog power-down, high while idle |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | RES | Conversion result |
| result_chan_o | output | CH_W | Channel of the result |

## Verification
The done strobe and the acceptance of a new request can fall in the same cycle. The bench starts every conversion in the cycle where it observes done_o, which provokes this overlap. It then judges the overlap by checking that busy_o rises and pd_o falls on the next edge, that the new conversion has the full expected latency, and that the previous result and channel were already correct in the done cycle. Other runs insert idle gaps, so the cold-start path from power-down is also timed.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAKE,
    ST_SAMPLE,
    ST_CONV
  } sar_state_e;

  typedef enum logic [1:0] {
    LD_WAKE,
    LD_SAMP,
    LD_STEP
  } sar_load_e;

endpackage

// File: rtl/sar_phase_timer.sv
module sar_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  // A loaded length of L yields max(L,1) cycles before expiry
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      if (load_val_i == '0) cnt_q <= '0;
      else                  cnt_q <= load_val_i - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int RES     = 10,
  parameter int LOW_RES = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           init_i,
  input  logic           step_i,
  input  logic           cmp_i,
  input  logic           mode8_i,
  output logic [RES-1:0] trial_o,
  output logic [RES-1:0] decided_o,
  output logic           last_o
);

  localparam int DROP = RES - LOW_RES;
  localparam logic [RES-1:0] TOP_BIT = {1'b1, {(RES-1){1'b0}}};

  logic [RES-1:0] acc_q;
  logic [RES-1:0] mask_q;

  assign decided_o = cmp_i ? (acc_q | mask_q) : acc_q;
  assign trial_o   = acc_q | mask_q;
  assign last_o    = mode8_i ? mask_q[DROP] : mask_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      mask_q <= '0;
    end else if (init_i) begin
      acc_q  <= '0;
      mask_q <= TOP_BIT;
    end else if (step_i) begin
      acc_q <= decided_o;
      if (last_o) mask_q <= '0;
      else        mask_q <= mask_q >> 1;
    end
  end

endmodule

// File: rtl/sar_ctrl_fsm.sv
module sar_ctrl_fsm
  import sar_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       expire_i,
  input  logic       last_i,
  output sar_state_e state_o,
  output logic       capture_o,
  output logic       tmr_load_o,
  output sar_load_e  tmr_sel_o,
  output logic       approx_init_o,
  output logic       approx_step_o,
  output logic       finish_o
);

  sar_state_e state_q, state_d;

  always_comb begin
    state_d       = state_q;
    capture_o     = 1'b0;
    tmr_load_o    = 1'b0;
    tmr_sel_o     = LD_WAKE;
    approx_init_o = 1'b0;
    approx_step_o = 1'b0;
    finish_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d    = ST_WAKE;
          capture_o  = 1'b1;
          tmr_load_o = 1'b1;
          tmr_sel_o  = LD_WAKE;
        end
      end
      ST_WAKE: begin
        if (expire_i) begin
          state_d    = ST_SAMPLE;
          tmr_load_o = 1'b1;
          tmr_sel_o  = LD_SAMP;
        end
      end
      ST_SAMPLE: begin
        if (expire_i) begin
          state_d       = ST_CONV;
          tmr_load_o    = 1'b1;
          tmr_sel_o     = LD_STEP;
          approx_init_o = 1'b1;
        end
      end
      ST_CONV: begin
        if (expire_i) begin
          approx_step_o = 1'b1;
          if (last_i) begin
            state_d  = ST_IDLE;
            finish_o = 1'b1;
          end else begin
            tmr_load_o = 1'b1;
            tmr_sel_o  = LD_STEP;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int RES      = 10,
  parameter int LOW_RES  = 8,
  parameter int CH_W     = 5,
  parameter int CNT_W    = 8,
  parameter int WAKE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic             mode8_i,
  input  logic [CNT_W-1:0] samp_len_i,
  input  logic [CNT_W-1:0] step_len_i,
  input  logic             cmp_i,
  output logic             sample_en_o,
  output logic [RES-1:0]   trial_code_o,
  output logic             pd_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES-1:0]   result_o,
  output logic [CH_W-1:0]  result_chan_o
);

  localparam logic [CNT_W-1:0] WAKE_LD = CNT_W'(WAKE_CYC);

  sar_state_e       state;
  sar_load_e        tmr_sel;
  logic             capture, tmr_load, approx_init, approx_step, finish;
  logic             expire, last_bit;
  logic [CNT_W-1:0] tmr_val;
  logic [RES-1:0]   decided;

  logic [CH_W-1:0]  cfg_chan_q;
  logic             cfg_mode8_q;
  logic [CNT_W-1:0] cfg_samp_q;
  logic [CNT_W-1:0] cfg_step_q;

  sar_ctrl_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .expire_i      (expire),
    .last_i        (last_bit),
    .state_o       (state),
    .capture_o     (capture),
    .tmr_load_o    (tmr_load),
    .tmr_sel_o     (tmr_sel),
    .approx_init_o (approx_init),
    .approx_step_o (approx_step),
    .finish_o      (finish)
  );

  // Configuration is latched only on an accepted request
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_chan_q  <= '0;
      cfg_mode8_q <= 1'b0;
      cfg_samp_q  <= '0;
      cfg_step_q  <= '0;
    end else if (capture) begin
      cfg_chan_q  <= chan_i;
      cfg_mode8_q <= mode8_i;
      cfg_samp_q  <= samp_len_i;
      cfg_step_q  <= step_len_i;
    end
  end

  always_comb begin
    unique case (tmr_sel)
      LD_WAKE: tmr_val = WAKE_LD;
      LD_SAMP: tmr_val = cfg_samp_q;
      default: tmr_val = cfg_step_q;
    endcase
  end

  sar_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expire_o   (expire)
  );

  sar_approx_reg #(.RES(RES), .LOW_RES(LOW_RES)) u_sar (
    .clk       (clk),
    .rst       (rst),
    .init_i    (approx_init),
    .step_i    (approx_step),
    .cmp_i     (cmp_i),
    .mode8_i   (cfg_mode8_q),
    .trial_o   (trial_code_o),
    .decided_o (decided),
    .last_o    (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o        <= 1'b0;
      result_o      <= '0;
      result_chan_o <= '0;
    end else begin
      done_o <= finish;
      if (finish) begin
        result_o      <= decided;
        result_chan_o <= cfg_chan_q;
      end
    end
  end

  assign busy_o      = (state != ST_IDLE);
  assign pd_o        = (state == ST_IDLE);
  assign sample_en_o = (state == ST_SAMPLE);

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int RES     = 10,
  parameter int LOW_RES = 8,
  parameter int CH_W    = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            busy_o,
  input logic            pd_o,
  input logic            sample_en_o,
  input logic            done_o,
  input logic [RES-1:0]  result_o,
  input logic [CH_W-1:0] result_chan_o,
  input logic            mode8_q
);

  localparam int DROP = RES - LOW_RES;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(result_o) && $stable(result_chan_o))); // R8

  AST_SAMPLE_POWERED: assert property (@(posedge clk) disable iff (rst)
    sample_en_o |-> (busy_o && !pd_o)); // R2

  AST_WAKE_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_en_o) |-> ($past(pd_o, 5) && !$past(pd_o, 4))); // R2

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done_o && mode8_q) |-> (result_o[DROP-1:0] == '0)); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && pd_o)); // R10

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
  .RES     (RES),
  .LOW_RES (LOW_RES),
  .CH_W    (CH_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .busy_o        (busy_o),
  .pd_o          (pd_o),
  .sample_en_o   (sample_en_o),
  .done_o        (done_o),
  .result_o      (result_o),
  .result_chan_o (result_chan_o),
  .mode8_q       (cfg_mode8_q)
);

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [4:0] chan_i = '0;
  logic       mode8_i = 1'b0;
  logic [7:0] samp_len_i = '0;
  logic [7:0] step_len_i = '0;
  logic       cmp_i;
  logic       sample_en_o, pd_o, busy_o, done_o;
  logic [9:0] trial_code_o, result_o;
  logic [4:0] result_chan_o;

  int vin_model = 0;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  // Ideal comparator: input at or above trial code
  assign cmp_i = (int'(trial_code_o) <= vin_model);

  sar_conv_ctrl u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i),
    .mode8_i(mode8_i), .samp_len_i(samp_len_i), .step_len_i(step_len_i),
    .cmp_i(cmp_i), .sample_en_o(sample_en_o), .trial_code_o(trial_code_o),
    .pd_o(pd_o), .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .result_chan_o(result_chan_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts a conversion from the current off-edge point and waits for done
  task automatic convert(input int v, input int ch, input bit m8,
                         input int s, input int t, input int inj);
    int se, te, bits, lat, n, first, scnt;
    se   = (s == 0) ? 1 : s;
    te   = (t == 0) ? 1 : t;
    bits = m8 ? 8 : 10;
    lat  = 4 + se + bits * te;
    vin_model  = v;
    chan_i     = 5'(ch);
    mode8_i    = m8;
    samp_len_i = 8'(s);
    step_len_i = 8'(t);
    start_i    = 1'b1;
    @(posedge clk); #1;
    start_i    = 1'b0;
    chan_i     = ~5'(ch);
    mode8_i    = ~m8;
    samp_len_i = 8'(s + 3);
    step_len_i = 8'(t + 2);
    chk(busy_o == 1'b1 && pd_o == 1'b0, "R2/R10 accept", {busy_o, pd_o}, 2);
    chk(done_o == 1'b0, "R8 single strobe", done_o, 0);
    n = 0; first = -1; scnt = 0;
    while (!done_o && n < 3000) begin
      @(posedge clk); #1;
      n++;
      start_i = (n == inj);
      if (sample_en_o) begin
        scnt++;
        if (first < 0) first = n;
      end
      if (n == 4 + se)
        chk(trial_code_o == 10'h200 && !sample_en_o, "R5 first trial", trial_code_o, 512);
    end
    start_i = 1'b0;
    chk(first == 4, "R2 wake delay", first, 4);
    chk(scnt == se, "R3 sample length", scnt, se);
    chk(n == lat, "R4 latency", n, lat);
    if (m8) chk(result_o == 10'(v & 'h3FC), "R7 reduced result", result_o, v & 'h3FC);
    else    chk(result_o == 10'(v), "R6 full result", result_o, v);
    chk(result_chan_o == 5'(ch), "R11/R9 channel", result_chan_o, ch);
    chk(!busy_o && pd_o, "R10 done idle", {busy_o, pd_o}, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(pd_o && !busy_o && !done_o && !sample_en_o, "R1 reset flags",
        {pd_o, busy_o, done_o, sample_en_o}, 8);
    chk(result_o == '0 && result_chan_o == '0, "R1 reset result", result_o, 0);
    @(negedge clk);

    // Full-resolution sweep, back-to-back starts in the done cycle
    for (int v = 0; v < 1024; v++)
      convert(v, v % 32, 1'b0, 1, 1, (v % 5 == 0) ? 1 + (v % 13) : -1);

    // Reduced-resolution sweep, zero lengths acting as one
    for (int v = 0; v < 1024; v++)
      convert(v, (v * 7) % 32, 1'b1, 0, 0, (v % 3 == 0) ? 2 + (v % 9) : -1);

    // Timing grid with idle gaps and busy-time starts in every phase
    for (int si = 0; si < 5; si++) begin
      for (int ti = 0; ti < 4; ti++) begin
        for (int m = 0; m < 2; m++) begin
          int s, t;
          s = (si == 0) ? 0 : (si == 1) ? 1 : (si == 2) ? 2 : (si == 3) ? 7 : 40;
          t = (ti == 0) ? 0 : (ti == 1) ? 1 : (ti == 2) ? 2 : 5;
          repeat (2) @(negedge clk);
          chk(pd_o && !busy_o, "R10 idle power-down", {pd_o, busy_o}, 2);
          chk(done_o == 1'b0, "R8 no strobe idle", done_o, 0);
          convert((si * 211 + ti * 97 + m * 331) % 1024, si * 4 + ti, m[0], s, t,
                  4 + ((s == 0) ? 1 : s) + 2);
          convert(1023 - si * 37 - ti, 31 - si, ~m[0], s, t, 3);
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule